// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block makes the shift clock for a synchronous serial master. The module clock is divided twice. The first stage divides by an even prescale value between 2 and 254. The second stage divides by one plus an 8-bit rate field. The serial clock therefore runs at the module clock divided by the product of the two factors. Neither stage can be set to give a serial clock faster than half the module clock. A link partner in slave mode that samples with this timing needs its own module clock to run at least twelve times the serial clock.

Besides the serial clock level, the block gives two single-cycle strobes, one for each rising and one for each falling serial clock edge. A shift register can then sample and launch data on module clock enables instead of on a derived clock. The serial clock sits low while the block is disabled. New divider settings are applied only at whole-period boundaries.

Top module: `bit_rate_gen`

## Requirements
- R1: With effective prescale P and rate field S, each serial clock half-period lasts (P/2)*(S+1) module clock cycles, and a full period lasts P*(S+1) cycles.
- R2: Bit 0 of the prescale input is ignored and taken as zero. A prescale input of 0 or 1 acts as 2, and 255 acts as 254.
- R3: The second-stage factor spans 1 (rate 0) to 256 (rate 255).
- R4: While enable is low, and after reset, the serial clock is low and both strobes are low.
- R5: The rise strobe is high for exactly the one cycle in which the serial clock first reads high. The fall strobe is high for exactly the one cycle in which it first reads low. The two strobes are never high together.
- R6: After enable is first sampled high at a clock edge, the serial clock stays low for one full half-period. Counting that edge as the first, it goes high on edge number (P/2)*(S+1).
- R7: Settings present while enable is low are used for the first period. A change to either setting while enabled takes effect from the falling edge that ends the current period, never mid-period.
- R8: Dropping enable forces the serial clock low at the next edge, with no fall strobe.
- R9: With prescale 2 and rate 0, the serial clock is half the module clock, and rise and fall strobes alternate on every cycle.
- R10: While enabled, the serial clock changes level only in a cycle that carries a matching strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the divider when high; idles it low when low |
| prescaleIn | input | 8 | First-stage even divisor (bit 0 ignored, minimum 2) |
| rateIn | input | 8 | Second-stage rate field; factor is value plus one |
| sclk | output | 1 | Serial clock level |
| riseStrobe | output | 1 | One-cycle pulse with each serial clock rising edge |
| fallStrobe | output | 1 | One-cycle pulse with each serial clock falling edge |

## Verification
The internal state is two counters and a latched copy of the settings, and all of it shows at the ports as edge timing.

A wrong terminal count in either stage moves the first rise strobe away from its expected cycle. That error appears within one half-period of enabling.

A settings register that loads at the wrong moment shows up in a different way. The period after a mid-run change has the wrong length, and this is visible by the second falling edge.

A counter that is not cleared on disable shows as a short first half-period after the next enable.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic clear;   // divider idle: force serial clock low, capture settings
    logic toggle;  // half-period complete: flip serial clock
  } brgCtrl_t;
endpackage

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8,
  localparam int HALF_W = PRE_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  brgCtrl_t          ctrl,
  input  logic [PRE_W-1:0]  prescaleIn,
  input  logic [RATE_W-1:0] rateIn,
  output logic [HALF_W-1:0] halfPreLim,
  output logic [RATE_W-1:0] rateLim,
  output logic              sclk,
  output logic              riseStrobe,
  output logic              fallStrobe
);
  logic [HALF_W-1:0] liveHalf;
  logic [HALF_W-1:0] heldHalf;
  logic [RATE_W-1:0] heldRate;
  logic              loadCfg;

  // Prescale/2 with LSB dropped; zero floors to one (prescale 2)
  always_comb begin
    liveHalf = prescaleIn[PRE_W-1:1];
    if (liveHalf == '0) liveHalf = HALF_W'(1);
  end

  // Settings refresh only while idle or at the falling edge ending a period
  assign loadCfg = ctrl.clear | (ctrl.toggle & sclk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldHalf <= HALF_W'(1);
      heldRate <= '0;
    end else if (loadCfg) begin
      heldHalf <= liveHalf;
      heldRate <= rateIn;
    end
  end

  assign halfPreLim = heldHalf - HALF_W'(1);
  assign rateLim    = heldRate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk       <= 1'b0;
      riseStrobe <= 1'b0;
      fallStrobe <= 1'b0;
    end else if (ctrl.clear) begin
      sclk       <= 1'b0;
      riseStrobe <= 1'b0;
      fallStrobe <= 1'b0;
    end else begin
      riseStrobe <= ctrl.toggle & ~sclk;
      fallStrobe <= ctrl.toggle & sclk;
      if (ctrl.toggle) sclk <= ~sclk;
    end
  end
endmodule

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8,
  localparam int HALF_W = PRE_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [HALF_W-1:0] halfPreLim,
  input  logic [RATE_W-1:0] rateLim,
  output brgCtrl_t          ctrl
);
  logic [HALF_W-1:0] preCnt;
  logic [RATE_W-1:0] rateCnt;
  logic              preEnd;
  logic              rateEnd;

  assign preEnd      = (preCnt == halfPreLim);
  assign rateEnd     = (rateCnt == rateLim);
  assign ctrl.clear  = ~enable;
  assign ctrl.toggle = enable & preEnd & rateEnd;

  // Stage one counts module clocks; stage two counts stage-one wraps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      rateCnt <= '0;
    end else if (!enable || ctrl.toggle) begin
      preCnt  <= '0;
      rateCnt <= '0;
    end else if (preEnd) begin
      preCnt  <= '0;
      rateCnt <= rateCnt + RATE_W'(1);
    end else begin
      preCnt  <= preCnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/bit_rate_gen.sv
module bit_rate_gen
  import brg_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [PRE_W-1:0]  prescaleIn,
  input  logic [RATE_W-1:0] rateIn,
  output logic              sclk,
  output logic              riseStrobe,
  output logic              fallStrobe
);
  localparam int HALF_W = PRE_W - 1;

  brgCtrl_t          ctrl;
  logic [HALF_W-1:0] halfPreLim;
  logic [RATE_W-1:0] rateLim;

  brg_ctrl #(.PRE_W(PRE_W), .RATE_W(RATE_W)) ctrlBlk (
    .clk(clk), .rstN(rstN), .enable(enable),
    .halfPreLim(halfPreLim), .rateLim(rateLim), .ctrl(ctrl)
  );

  brg_datapath #(.PRE_W(PRE_W), .RATE_W(RATE_W)) dataBlk (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .prescaleIn(prescaleIn), .rateIn(rateIn),
    .halfPreLim(halfPreLim), .rateLim(rateLim),
    .sclk(sclk), .riseStrobe(riseStrobe), .fallStrobe(fallStrobe)
  );
endmodule

// File: rtl/brg_checks.sv
module brg_checks (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclk,
  input logic riseStrobe,
  input logic fallStrobe
);
  // R5
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(riseStrobe && fallStrobe));
  // R5
  rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> (sclk && !$past(sclk)));
  // R5
  fall_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> (!sclk && $past(sclk)));
  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (!sclk && !riseStrobe && !fallStrobe));
  // R10
  change_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && (sclk != $past(sclk))) |-> (riseStrobe || fallStrobe));
endmodule

bind bit_rate_gen brg_checks brgChk (
  .clk(clk), .rstN(rstN), .enable(enable),
  .sclk(sclk), .riseStrobe(riseStrobe), .fallStrobe(fallStrobe)
);

// File: tb/bit_rate_gen_test.sv
module bit_rate_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] prescaleIn = 8'd2;
  logic [7:0] rateIn = 8'd0;
  logic       sclk, riseStrobe, fallStrobe;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bit_rate_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .prescaleIn(prescaleIn), .rateIn(rateIn),
    .sclk(sclk), .riseStrobe(riseStrobe), .fallStrobe(fallStrobe)
  );

  // {prescale, rate, expected half-period}
  localparam logic [31:0] VEC [9] = '{
    {8'd2,   8'd0, 16'd1},    // R9 fastest
    {8'd2,   8'd1, 16'd2},    // R1
    {8'd4,   8'd2, 16'd6},    // R1
    {8'd6,   8'd0, 16'd3},    // R1
    {8'd0,   8'd0, 16'd1},    // R2 zero floors to 2
    {8'd1,   8'd3, 16'd4},    // R2 one acts as 2
    {8'd5,   8'd1, 16'd4},    // R2 odd drops LSB
    {8'd10,  8'd4, 16'd25},   // R1
    {8'd255, 8'd0, 16'd127}   // R2 top value acts as 254
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleSetup(input logic [7:0] p, input logic [7:0] r);
    @(negedge clk);
    enable = 1'b0;
    prescaleIn = p;
    rateIn = r;
    repeat (2) @(negedge clk);
  endtask

  // Wait for a strobe; returns negedges elapsed, or -1 on timeout
  task automatic waitStrobe(input bit wantRise, input int limit, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (wantRise ? riseStrobe : fallStrobe) return;
      if (n > limit) begin n = -1; return; end
    end
  endtask

  task automatic runVector(input logic [7:0] p, input logic [7:0] r, input int h);
    int n;
    idleSetup(p, r);
    enable = 1'b1;
    waitStrobe(1'b1, 3 * h + 4, n);
    check(n == h, "R6 first rise (R1/R2/R3)", n, h);
    check(sclk === 1'b1, "R5 sclk high with rise", sclk, 1);
    waitStrobe(1'b0, 3 * h + 4, n);
    check(n == h, "R1 rise-to-fall", n, h);
    check(sclk === 1'b0 && riseStrobe === 1'b0, "R5 low with fall", sclk, 0);
    @(negedge clk);
    check(fallStrobe === 1'b0, "R5 fall strobe one cycle", fallStrobe, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(sclk === 1'b0 && riseStrobe === 1'b0 && fallStrobe === 1'b0, "R4 reset", sclk, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk === 1'b0 && riseStrobe === 1'b0 && fallStrobe === 1'b0, "R4 disabled idle", sclk, 0);

    foreach (VEC[i]) runVector(VEC[i][31:24], VEC[i][23:16], int'(VEC[i][15:0]));

    // R9: strobes alternate every cycle at the fastest setting
    idleSetup(8'd2, 8'd0);
    enable = 1'b1;
    @(negedge clk);
    check(riseStrobe === 1'b1, "R9 rise cycle 1", riseStrobe, 1);
    @(negedge clk);
    check(fallStrobe === 1'b1 && riseStrobe === 1'b0, "R9 fall cycle 2", fallStrobe, 1);
    @(negedge clk);
    check(riseStrobe === 1'b1 && sclk === 1'b1, "R9 rise cycle 3", riseStrobe, 1);

    // R3: largest factor, prescale 254 and rate 255
    idleSetup(8'd254, 8'd255);
    enable = 1'b1;
    waitStrobe(1'b1, 40000, n);
    check(n == 32512, "R3 max divisor half-period", n, 32512);

    // R7: a mid-period rate change waits for the period boundary
    idleSetup(8'd2, 8'd1);
    enable = 1'b1;
    waitStrobe(1'b1, 20, n);
    check(n == 2, "R7 first rise old setting", n, 2);
    rateIn = 8'd3;
    waitStrobe(1'b0, 20, n);
    check(n == 2, "R7 current period keeps old setting", n, 2);
    waitStrobe(1'b1, 20, n);
    check(n == 4, "R7 new setting after boundary", n, 4);
    waitStrobe(1'b0, 20, n);
    check(n == 4, "R7 new setting second half", n, 4);

    // R8: dropping enable while high forces low with no fall strobe
    waitStrobe(1'b1, 20, n);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(sclk === 1'b0, "R8 forced low", sclk, 0);
    check(fallStrobe === 1'b0 && riseStrobe === 1'b0, "R8 no strobe", fallStrobe, 0);
    repeat (5) @(negedge clk);
    check(sclk === 1'b0 && riseStrobe === 1'b0, "R4 stays idle", sclk, 0);

    // R6: re-enable restarts with a full half-period
    enable = 1'b1;
    waitStrobe(1'b1, 20, n);
    check(n == 4, "R6 restart full half-period", n, 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule